// File: doc/BRIEF.md
# CPU Interrupt Entry Sequencer

This block is the part of a 16-bit segmented processor core that decides, at each instruction boundary, whether control must leave the running program, and then carries out the switch. It looks at four kinds of request: an internal exception raised by the execution unit, a latched rising edge on the non-maskable line, a level request from an external controller, and the single-step flag. The winner gives an 8-bit interrupt type. For the external request the type is read from the data bus in an acknowledge cycle. For the other kinds the type is fixed.

The entry sequence saves a three-word frame on the stack and clears the interrupt-enable and step flags. It then loads the new instruction pointer and code segment from a vector table in the lowest kilobyte of memory, with four bytes per type. A return strobe runs the reverse sequence and unwinds the frame. All memory traffic goes through one word-wide request/acknowledge port. A request stays asserted until the memory acknowledges it. The execution unit marks instruction boundaries with a strobe and may write the flags word while the sequencer is idle.

Top module: `irq_entry_seq`

## Requirements
- R1: When `boundary_i` is high in idle, requests are ranked: exception over non-maskable edge over external request (only if flags bit 9 = 1) over single-step (flags bit 8 = 1). The highest one present starts an entry. The type used is the exception's type, 2, the acknowledged byte, or 1.
- R2: The vector for type n is fetched as two reads. The new IP is read from byte address 4n and the new CS from byte address 4n+2. Both addresses lie below 1024.
- R3: An external request while flags bit 9 = 0, with no other request pending, starts no sequence. `busy_o` stays low and no memory request is issued.
- R4: A rising edge on `nmi_i` is latched and serviced as type 2 whatever the state of flags bit 9. An edge that arrives while a sequence runs, or in the same cycle as a pending edge is taken, stays pending for a later boundary.
- R5: `exc_code_i` selects the exception type: code 0 gives type 0, code 1 gives type 3, code 2 gives type 4 and code 3 gives type 1. Flags bit 9 does not mask these.
- R6: An entry caused by the external request makes exactly one acknowledge cycle (`mem_inta_o` = 1). The type is taken from `mem_rdata_i[7:0]` of that cycle. No other entry makes an acknowledge cycle.
- R7: The entry writes the flags word, then CS, then IP. Before each write SP is lowered by 2, and the word is stored at SS×16+SP (20 bits). After the frame is written, SP has dropped by 6. Flags bits 9 and 8 are cleared and the other flag bits are unchanged.
- R8: When `ret_i` is pulsed in idle, the block reads IP, then CS, then flags from SS×16+SP, raising SP by 2 after each read, for a total rise of 6.
- R9: After reset: CS = FFFFh, IP = SS = SP = 0000h, all flags are 0, and the block is idle. The first fetch address SS-independent CS×16+IP is therefore FFFF0h.
- R10: While a sequence runs, `boundary_i` and `flag_we_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boundary_i | input | 1 | Instruction-boundary strobe |
| ret_i | input | 1 | Start the return sequence (idle only) |
| exc_req_i | input | 1 | Internal exception request, sampled at a boundary |
| exc_code_i | input | 2 | Exception kind |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| intr_i | input | 1 | Maskable external request, level |
| flag_we_i | input | 1 | Flags write from execution (idle only) |
| flag_d_i | input | 16 | Flags write data |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_inta_o | output | 1 | Request is an interrupt acknowledge |
| mem_addr_o | output | 20 | Physical byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| mem_ack_i | input | 1 | Memory acknowledge, completes the request |
| busy_o | output | 1 | A sequence is running |
| cs_o | output | 16 | Code segment |
| ip_o | output | 16 | Instruction pointer |
| ss_o | output | 16 | Stack segment |
| sp_o | output | 16 | Stack pointer |
| flags_o | output | 16 | Flags word |

## Verification
The hard overlap is between a new non-maskable edge and the sequencer's own handling of requests. One case is an edge that lands in the very cycle a pending edge is taken. The other is an edge that lands in the middle of an entry already under way while a boundary strobe is also pulsed. The bench creates the first case by raising `nmi_i` in the same cycle as `boundary_i`, with an older edge already latched. It creates the second by pulsing `nmi_i` and `boundary_i` together a cycle after an external-request entry starts. It judges both by the vector that was loaded and by whether exactly one further type-2 entry follows at the next boundary. It also sweeps every combination of the four requests and the enable flag against an ordering model, and runs all 256 acknowledged type numbers through entry and return.

// File: rtl/ies_pkg.sv
package ies_pkg;
  parameter int SEG_W     = 16;
  parameter int ADDR_W    = 20;
  parameter int TYPE_W    = 8;
  parameter int SEG_SHIFT = 4;
  parameter int VEC_SHIFT = 2;
  parameter int NMI_TYPE  = 2;
  parameter int STEP_TYPE = 1;

  typedef enum logic [3:0] {
    S_IDLE, S_ACK, S_PSH_FL, S_PSH_CS, S_PSH_IP,
    S_VEC_IP, S_VEC_CS, S_POP_IP, S_POP_CS, S_POP_FL
  } seq_state_e;

  typedef enum logic [1:0] {SRC_EXC, SRC_NMI, SRC_INTR, SRC_STEP} src_e;

  function automatic logic [ADDR_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                  input logic [SEG_W-1:0] off);
    logic [ADDR_W-1:0] base;
    base = ADDR_W'(seg) << SEG_SHIFT;
    return base + ADDR_W'(off);
  endfunction

  function automatic logic [TYPE_W-1:0] exc_type(input logic [1:0] code);
    case (code)
      2'd0:    return TYPE_W'(0);
      2'd1:    return TYPE_W'(3);
      2'd2:    return TYPE_W'(4);
      default: return TYPE_W'(1);
    endcase
  endfunction
endpackage

// File: rtl/ies_arbiter.sv
module ies_arbiter
  import ies_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              nmi_i,
  input  logic              nmi_take_i,
  input  logic              exc_req_i,
  input  logic [1:0]        exc_code_i,
  input  logic              intr_i,
  input  logic              if_i,
  input  logic              tf_i,
  output logic              hit_o,
  output src_e              src_o,
  output logic [TYPE_W-1:0] type_o
);
  logic nmi_q;
  logic nmi_pend;
  logic nmi_edge;

  assign nmi_edge = nmi_i & ~nmi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_i;
      nmi_pend <= (nmi_pend & ~nmi_take_i) | nmi_edge;
    end
  end

  always_comb begin
    hit_o  = 1'b1;
    src_o  = SRC_EXC;
    type_o = '0;
    if (exc_req_i) begin
      type_o = exc_type(exc_code_i);
    end else if (nmi_pend) begin
      src_o  = SRC_NMI;
      type_o = TYPE_W'(NMI_TYPE);
    end else if (intr_i && if_i) begin
      src_o  = SRC_INTR;
    end else if (tf_i) begin
      src_o  = SRC_STEP;
      type_o = TYPE_W'(STEP_TYPE);
    end else begin
      hit_o  = 1'b0;
    end
  end

  // R4: a fresh edge is never lost, even when taken in the same cycle
  p_nmi_edge_latched_r4: assert property (@(posedge clk) disable iff (rst)
    nmi_edge |=> nmi_pend);
  // R4: a pending edge survives until the sequencer takes it
  p_nmi_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (nmi_pend && !nmi_take_i) |=> nmi_pend);
  // R3: a masked external request alone never wins
  p_intr_masked_r3: assert property (@(posedge clk) disable iff (rst)
    (intr_i && !if_i && !exc_req_i && !nmi_pend && !tf_i) |-> !hit_o);
endmodule

// File: rtl/ies_sequencer.sv
module ies_sequencer
  import ies_pkg::*;
#(
  parameter logic [SEG_W-1:0] RST_CS = 16'hFFFF,
  parameter int               IF_BIT = 9,
  parameter int               TF_BIT = 8
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              boundary_i,
  input  logic              ret_i,
  input  logic              flag_we_i,
  input  logic [SEG_W-1:0]  flag_d_i,
  input  logic              hit_i,
  input  src_e              src_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic              ack_i,
  input  logic [SEG_W-1:0]  rdata_i,
  output seq_state_e        state_o,
  output logic [TYPE_W-1:0] vtype_o,
  output logic              nmi_take_o,
  output logic [SEG_W-1:0]  cs_o,
  output logic [SEG_W-1:0]  ip_o,
  output logic [SEG_W-1:0]  ss_o,
  output logic [SEG_W-1:0]  sp_o,
  output logic [SEG_W-1:0]  flags_o
);
  localparam logic [SEG_W-1:0] WORD_BYTES = SEG_W'(SEG_W / 8);

  seq_state_e        state_q;
  logic [TYPE_W-1:0] vtype_q;
  logic [SEG_W-1:0]  cs_q, ip_q, ss_q, sp_q, flags_q;
  logic              start;

  assign start      = (state_q == S_IDLE) && boundary_i && !ret_i && hit_i;
  assign nmi_take_o = start && (src_i == SRC_NMI);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      vtype_q <= '0;
      cs_q    <= RST_CS;
      ip_q    <= '0;
      ss_q    <= '0;
      sp_q    <= '0;
      flags_q <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          if (ret_i) begin
            state_q <= S_POP_IP;
          end else if (start) begin
            vtype_q <= type_i;
            state_q <= (src_i == SRC_INTR) ? S_ACK : S_PSH_FL;
          end else if (flag_we_i) begin
            flags_q <= flag_d_i;
          end
        end
        S_ACK: if (ack_i) begin
          vtype_q <= rdata_i[TYPE_W-1:0];
          state_q <= S_PSH_FL;
        end
        S_PSH_FL: if (ack_i) begin
          sp_q            <= sp_q - WORD_BYTES;
          flags_q[IF_BIT] <= 1'b0;
          flags_q[TF_BIT] <= 1'b0;
          state_q         <= S_PSH_CS;
        end
        S_PSH_CS: if (ack_i) begin
          sp_q    <= sp_q - WORD_BYTES;
          state_q <= S_PSH_IP;
        end
        S_PSH_IP: if (ack_i) begin
          sp_q    <= sp_q - WORD_BYTES;
          state_q <= S_VEC_IP;
        end
        S_VEC_IP: if (ack_i) begin
          ip_q    <= rdata_i;
          state_q <= S_VEC_CS;
        end
        S_VEC_CS: if (ack_i) begin
          cs_q    <= rdata_i;
          state_q <= S_IDLE;
        end
        S_POP_IP: if (ack_i) begin
          ip_q    <= rdata_i;
          sp_q    <= sp_q + WORD_BYTES;
          state_q <= S_POP_CS;
        end
        S_POP_CS: if (ack_i) begin
          cs_q    <= rdata_i;
          sp_q    <= sp_q + WORD_BYTES;
          state_q <= S_POP_FL;
        end
        S_POP_FL: if (ack_i) begin
          flags_q <= rdata_i;
          sp_q    <= sp_q + WORD_BYTES;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign vtype_o = vtype_q;
  assign cs_o    = cs_q;
  assign ip_o    = ip_q;
  assign ss_o    = ss_q;
  assign sp_o    = sp_q;
  assign flags_o = flags_q;

  // R7: each push lowers the stack pointer by one word
  p_push_sp_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {S_PSH_FL, S_PSH_CS, S_PSH_IP} && ack_i)
      |=> sp_q == $past(sp_q) - WORD_BYTES);
  // R7: enable and step flags are clear once the flags word is saved
  p_mask_after_save_r7: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_PSH_FL && ack_i) |=> (!flags_q[IF_BIT] && !flags_q[TF_BIT]));
  // R8: each pop raises the stack pointer by one word
  p_pop_sp_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {S_POP_IP, S_POP_CS, S_POP_FL} && ack_i)
      |=> sp_q == $past(sp_q) + WORD_BYTES);
  // R10: flags are untouched by the execution write port while busy
  p_busy_flags_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q inside {S_ACK, S_PSH_CS, S_PSH_IP, S_VEC_IP, S_VEC_CS, S_POP_IP, S_POP_CS})
      |=> flags_q == $past(flags_q));
  // R9: state right after reset release
  p_reset_state_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (cs_q == RST_CS && ip_q == '0 && sp_q == '0 && ss_q == '0
                    && flags_q == '0 && state_q == S_IDLE));
endmodule

// File: rtl/ies_bus_drv.sv
module ies_bus_drv
  import ies_pkg::*;
(
  input  seq_state_e        state_i,
  input  logic [TYPE_W-1:0] vtype_i,
  input  logic [SEG_W-1:0]  cs_i,
  input  logic [SEG_W-1:0]  ip_i,
  input  logic [SEG_W-1:0]  ss_i,
  input  logic [SEG_W-1:0]  sp_i,
  input  logic [SEG_W-1:0]  flags_i,
  output logic              req_o,
  output logic              we_o,
  output logic              inta_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SEG_W-1:0]  wdata_o
);
  localparam int PAD_W = ADDR_W - TYPE_W - VEC_SHIFT;
  localparam logic [SEG_W-1:0] WORD_BYTES = SEG_W'(SEG_W / 8);

  logic [ADDR_W-1:0] vec_base;
  logic [ADDR_W-1:0] push_addr;
  logic [ADDR_W-1:0] pop_addr;

  assign vec_base  = {{PAD_W{1'b0}}, vtype_i, {VEC_SHIFT{1'b0}}};
  assign push_addr = phys_addr(ss_i, sp_i - WORD_BYTES);
  assign pop_addr  = phys_addr(ss_i, sp_i);

  always_comb begin
    req_o   = (state_i != S_IDLE);
    we_o    = 1'b0;
    inta_o  = 1'b0;
    addr_o  = '0;
    wdata_o = '0;
    case (state_i)
      S_ACK:    inta_o = 1'b1;
      S_PSH_FL: begin we_o = 1'b1; addr_o = push_addr; wdata_o = flags_i; end
      S_PSH_CS: begin we_o = 1'b1; addr_o = push_addr; wdata_o = cs_i;    end
      S_PSH_IP: begin we_o = 1'b1; addr_o = push_addr; wdata_o = ip_i;    end
      S_VEC_IP: addr_o = vec_base;
      S_VEC_CS: addr_o = vec_base + ADDR_W'(WORD_BYTES);
      S_POP_IP, S_POP_CS, S_POP_FL: addr_o = pop_addr;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import ies_pkg::*;
#(
  parameter logic [15:0] RST_CS = 16'hFFFF,
  parameter int          IF_BIT = 9,
  parameter int          TF_BIT = 8
)(
  input  logic        clk,
  input  logic        rst,
  input  logic        boundary_i,
  input  logic        ret_i,
  input  logic        exc_req_i,
  input  logic [1:0]  exc_code_i,
  input  logic        nmi_i,
  input  logic        intr_i,
  input  logic        flag_we_i,
  input  logic [15:0] flag_d_i,
  output logic        mem_req_o,
  output logic        mem_we_o,
  output logic        mem_inta_o,
  output logic [19:0] mem_addr_o,
  output logic [15:0] mem_wdata_o,
  input  logic [15:0] mem_rdata_i,
  input  logic        mem_ack_i,
  output logic        busy_o,
  output logic [15:0] cs_o,
  output logic [15:0] ip_o,
  output logic [15:0] ss_o,
  output logic [15:0] sp_o,
  output logic [15:0] flags_o
);
  localparam int VEC_TOP = TYPE_W + VEC_SHIFT;

  logic              hit;
  src_e              src;
  logic [TYPE_W-1:0] req_type;
  logic              nmi_take;
  seq_state_e        state;
  logic [TYPE_W-1:0] vtype;

  ies_arbiter u_arb (
    .clk        (clk),
    .rst        (rst),
    .nmi_i      (nmi_i),
    .nmi_take_i (nmi_take),
    .exc_req_i  (exc_req_i),
    .exc_code_i (exc_code_i),
    .intr_i     (intr_i),
    .if_i       (flags_o[IF_BIT]),
    .tf_i       (flags_o[TF_BIT]),
    .hit_o      (hit),
    .src_o      (src),
    .type_o     (req_type)
  );

  ies_sequencer #(.RST_CS(RST_CS), .IF_BIT(IF_BIT), .TF_BIT(TF_BIT)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .boundary_i (boundary_i),
    .ret_i      (ret_i),
    .flag_we_i  (flag_we_i),
    .flag_d_i   (flag_d_i),
    .hit_i      (hit),
    .src_i      (src),
    .type_i     (req_type),
    .ack_i      (mem_ack_i),
    .rdata_i    (mem_rdata_i),
    .state_o    (state),
    .vtype_o    (vtype),
    .nmi_take_o (nmi_take),
    .cs_o       (cs_o),
    .ip_o       (ip_o),
    .ss_o       (ss_o),
    .sp_o       (sp_o),
    .flags_o    (flags_o)
  );

  ies_bus_drv u_bus (
    .state_i (state),
    .vtype_i (vtype),
    .cs_i    (cs_o),
    .ip_i    (ip_o),
    .ss_i    (ss_o),
    .sp_i    (sp_o),
    .flags_i (flags_o),
    .req_o   (mem_req_o),
    .we_o    (mem_we_o),
    .inta_o  (mem_inta_o),
    .addr_o  (mem_addr_o),
    .wdata_o (mem_wdata_o)
  );

  assign busy_o = (state != S_IDLE);

  // R2: vector reads stay inside the low vector window
  p_vec_window_r2: assert property (@(posedge clk) disable iff (rst)
    (state inside {S_VEC_IP, S_VEC_CS}) |-> (mem_addr_o[19:VEC_TOP] == '0 && !mem_we_o));
  // R6: acknowledge cycles are reads issued as requests
  p_inta_is_request_r6: assert property (@(posedge clk) disable iff (rst)
    mem_inta_o |-> (mem_req_o && !mem_we_o));
  // R3: idle means a silent memory port
  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !mem_req_o);
endmodule

// File: tb/test_irq_entry_seq.sv
module test_irq_entry_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] F_IF = 16'h0200;
  localparam logic [15:0] F_TF = 16'h0100;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boundary_i = 1'b0, ret_i = 1'b0, exc_req_i = 1'b0;
  logic [1:0]  exc_code_i = 2'd0;
  logic        nmi_i = 1'b0, intr_i = 1'b0, flag_we_i = 1'b0;
  logic [15:0] flag_d_i = '0;
  logic        mem_req_o, mem_we_o, mem_inta_o, busy_o;
  logic [19:0] mem_addr_o;
  logic [15:0] mem_wdata_o, cs_o, ip_o, ss_o, sp_o, flags_o;
  logic [15:0] mem_rdata_i = '0;
  logic        mem_ack_i = 1'b0;

  irq_entry_seq i_irq_entry_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;
  int lat     = 0;
  int wait_cnt = 0;
  int inta_cnt = 0;
  int mid_mode = 0;
  logic [7:0]  intr_type = 8'h00;
  logic [15:0] mem [int];
  logic [15:0] g_cs, g_ip, g_fl, g_sp;

  function automatic logic [15:0] exp_ip(input int n);
    return 16'(16'h0010 + n * 16'h0101);
  endfunction
  function automatic logic [15:0] exp_cs(input int n);
    return 16'hC000 | 16'(n);
  endfunction
  function automatic int phys(input logic [15:0] seg, input logic [15:0] off);
    return (int'(seg) * 16 + int'(off)) % (1 << 20);
  endfunction
  function automatic logic [15:0] rd(input int a);
    if (mem.exists(a)) return mem[a];
    return 16'h0000;
  endfunction
  function automatic logic [7:0] exc_map(input int c);
    case (c)
      0: return 8'd0;
      1: return 8'd3;
      2: return 8'd4;
      default: return 8'd1;
    endcase
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      n_fail++;
      $display("FAIL watchdog (all R) act=%0d exp=<150000", cycles);
      finish_run();
    end
  end

  // memory responder, works between clock edges
  always @(negedge clk) begin
    if (rst) begin
      mem_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (mem_ack_i) begin
      mem_ack_i = 1'b0;
      wait_cnt  = 0;
    end else if (mem_req_o) begin
      if (wait_cnt >= lat) begin
        mem_ack_i = 1'b1;
        if (mem_inta_o) begin
          mem_rdata_i = {8'h00, intr_type};
          inta_cnt++;
        end else if (mem_we_o) begin
          mem[int'(mem_addr_o)] = mem_wdata_o;
        end else begin
          mem_rdata_i = rd(int'(mem_addr_o));
        end
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic write_flags(input logic [15:0] v);
    @(negedge clk); flag_we_i = 1'b1; flag_d_i = v;
    @(negedge clk); flag_we_i = 1'b0;
  endtask

  task automatic pulse_nmi();
    @(negedge clk); nmi_i = 1'b1;
    @(negedge clk); nmi_i = 1'b0;
  endtask

  task automatic do_entry(input logic [7:0] t, input bit via_intr, input string req);
    int a_fl, a_cs, a_ip, i0;
    g_cs = cs_o; g_ip = ip_o; g_fl = flags_o; g_sp = sp_o;
    a_fl = phys(ss_o, 16'(g_sp - 16'd2));
    a_cs = phys(ss_o, 16'(g_sp - 16'd4));
    a_ip = phys(ss_o, 16'(g_sp - 16'd6));
    mem[a_fl] = 16'hA5A5; mem[a_cs] = 16'hA5A5; mem[a_ip] = 16'hA5A5;
    i0 = inta_cnt;
    @(negedge clk); boundary_i = 1'b1;
    if (mid_mode == 3) nmi_i = 1'b1;
    @(negedge clk); boundary_i = 1'b0; nmi_i = 1'b0;
    chk({req, " busy after boundary"}, 32'(busy_o), 32'd1);
    if (mid_mode == 1) begin
      flag_we_i = 1'b1; flag_d_i = 16'hFFFF;       // R10 poke while busy
      @(negedge clk); flag_we_i = 1'b0;
    end else if (mid_mode == 2) begin
      nmi_i = 1'b1; boundary_i = 1'b1;             // R4 / R10 overlap
      @(negedge clk); nmi_i = 1'b0; boundary_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    chk({req, " R2 new IP"}, 32'(ip_o), 32'(exp_ip(t)));
    chk({req, " R2 new CS"}, 32'(cs_o), 32'(exp_cs(t)));
    chk("R7 SP after frame", 32'(sp_o), 32'(16'(g_sp - 16'd6)));
    chk("R7 flags masked", 32'(flags_o), 32'(g_fl & ~(F_IF | F_TF)));
    chk("R7 saved flags", 32'(rd(a_fl)), 32'(g_fl));
    chk("R7 saved CS", 32'(rd(a_cs)), 32'(g_cs));
    chk("R7 saved IP", 32'(rd(a_ip)), 32'(g_ip));
    chk("R6 acknowledge count", 32'(inta_cnt - i0), via_intr ? 32'd1 : 32'd0);
  endtask

  task automatic do_ret();
    @(negedge clk); ret_i = 1'b1;
    @(negedge clk); ret_i = 1'b0;
    while (busy_o) @(negedge clk);
    chk("R8 IP restored", 32'(ip_o), 32'(g_ip));
    chk("R8 CS restored", 32'(cs_o), 32'(g_cs));
    chk("R8 flags restored", 32'(flags_o), 32'(g_fl));
    chk("R8 SP restored", 32'(sp_o), 32'(g_sp));
  endtask

  task automatic expect_none(input string req);
    @(negedge clk); boundary_i = 1'b1;
    @(negedge clk); boundary_i = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk({req, " stays idle"}, 32'({busy_o, mem_req_o}), 32'd0);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int n = 0; n < 256; n++) begin
      mem[4*n]     = exp_ip(n);
      mem[4*n + 2] = exp_cs(n);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    chk("R9 CS", 32'(cs_o), 32'hFFFF);
    chk("R9 IP", 32'(ip_o), 32'h0);
    chk("R9 SS", 32'(ss_o), 32'h0);
    chk("R9 SP", 32'(sp_o), 32'h0);
    chk("R9 flags", 32'(flags_o), 32'h0);
    chk("R9 idle", 32'({busy_o, mem_req_o}), 32'h0);
    chk("R9 first fetch", 32'(phys(cs_o, ip_o)), 32'hFFFF0);

    // R3 masked external request
    intr_i = 1'b1;
    expect_none("R3 masked intr");
    intr_i = 1'b0;

    // R6 / R2 sweep of all acknowledged types
    for (int t = 0; t < 256; t++) begin
      lat = t % 3;
      write_flags(F_IF | (16'(t) & 16'h00D5));
      intr_type = 8'(t);
      intr_i = 1'b1;
      mid_mode = (t == 5) ? 1 : 0;
      do_entry(8'(t), 1'b1, "R6 intr");
      mid_mode = 0;
      intr_i = 1'b0;
      do_ret();
    end
    write_flags(16'h0000);

    // R5 exception kinds with enable clear
    for (int c = 0; c < 4; c++) begin
      exc_req_i = 1'b1; exc_code_i = 2'(c);
      do_entry(exc_map(c), 1'b0, "R5 exception");
      exc_req_i = 1'b0;
      do_ret();
    end

    // R4 non-maskable with enable clear
    pulse_nmi();
    do_entry(8'd2, 1'b0, "R4 nmi");
    do_ret();
    expect_none("R4 nmi consumed");

    // R1 single step
    write_flags(F_TF | 16'h0041);
    do_entry(8'd1, 1'b0, "R1 step");
    do_ret();
    write_flags(16'h0000);

    // R1 ordering sweep over every request combination
    for (int m = 0; m < 32; m++) begin
      bit e, n, i, s, f, entered;
      logic [7:0] et;
      e = m[0]; n = m[1]; i = m[2]; s = m[3]; f = m[4];
      lat = m % 2;
      write_flags((f ? F_IF : 16'h0) | (s ? F_TF : 16'h0));
      exc_code_i = 2'((m >> 1) & 3);
      exc_req_i = e; intr_i = i; intr_type = 8'h80 + 8'(m);
      if (n) pulse_nmi();
      entered = 1'b1;
      if (e)           et = exc_map((m >> 1) & 3);
      else if (n)      et = 8'd2;
      else if (i && f) et = 8'h80 + 8'(m);
      else if (s)      et = 8'd1;
      else begin       et = 8'd0; entered = 1'b0; end
      if (entered) begin
        do_entry(et, !e && !n && i && f, "R1 order");
        exc_req_i = 1'b0; intr_i = 1'b0;
        do_ret();
      end else begin
        expect_none("R1 no request");
        exc_req_i = 1'b0; intr_i = 1'b0;
      end
      write_flags(16'h0000);
      if (e && n) begin
        do_entry(8'd2, 1'b0, "R1 nmi left pending");
        do_ret();
      end
    end

    // R4 / R10 edge and boundary during a running entry
    lat = 2;
    write_flags(F_IF);
    intr_i = 1'b1; intr_type = 8'h40;
    mid_mode = 2;
    do_entry(8'h40, 1'b1, "R10 boundary while busy");
    mid_mode = 0;
    intr_i = 1'b0;
    do_ret();
    do_entry(8'd2, 1'b0, "R4 edge during entry");
    do_ret();
    expect_none("R4 single pending");

    // R4 new edge in the cycle the old one is taken
    lat = 0;
    write_flags(16'h0000);
    pulse_nmi();
    mid_mode = 3;
    do_entry(8'd2, 1'b0, "R4 first of two");
    mid_mode = 0;
    do_ret();
    do_entry(8'd2, 1'b0, "R4 coincident edge kept");
    do_ret();
    expect_none("R4 both consumed");

    finish_run();
  end
endmodule